// File: doc/BRIEF.md
# Antifuse One-Time-Programmable Array Page Programmer and Word Reader

This block sits between a host and a one-time-programmable array of 16K words of 16 bits built from gate-oxide antifuse cells. The host fills a 32-byte page buffer one byte at a time, then issues a program command. The controller then presents the whole page to the array at once and holds a single long programming strobe. A one bit in the page breaks the oxide of its cell, which then stores a one for good. A zero bit leaves its cell intact.

The host reads one 16-bit word at a time. The controller applies the word address first, then raises the array read enable and waits a configurable settle time. It then enables exactly one bank of 16 sense amplifiers, chosen by sector and column group, and latches the word. A one-cycle valid pulse reports the result. Programming and reading never overlap. While an operation is in progress the block reports busy, and it drops any command that arrives in that time.

Top module: `otp_page_ctrl`

## Requirements
- R1: The 14-bit word address drives the array as row = address[13:6] and column = address[5:0]. During programming the array sees the base word of the open page, with address[3:0] = 0.
- R2: A program cycle presents all 256 page bits together on `arr_din`. Byte b of the page (byte address[4:0] = b) sits at `arr_din[8b+7:8b]`, so a word holds its even byte in bits 7:0.
- R3: A one bit in the page sets its cell. A zero bit leaves the cell unchanged, so programming a page again can only add ones to it.
- R4: `arr_pgm` stays high for exactly PULSE_CYC cycles per program command. Row, column and `arr_din` stay stable for the whole pulse.
- R5: A read accepted at edge n puts the address on the array after edge n. `arr_rd_en` is high in cycles n+1 to n+1+SETTLE_CYC, and `arr_sa_en` is high only in the last of those cycles. The word present in that cycle appears on `rd_data`, with `rd_valid` high for the single cycle n+2+SETTLE_CYC.
- R6: `arr_sa_grp` is one-hot during the sense cycle, with index = address[13:12]*4 + address[5:4]. It is all zeros in every other cycle.
- R7: `arr_rd_en` and `arr_pgm` are never high in the same cycle.
- R8: Once a byte has opened a page, a load to a different 32-byte page before the next program command is ignored. `page_err` then goes high for the one cycle after that load.
- R9: The page buffer is cleared after every program cycle, so a byte that was not loaded again burns nothing.
- R10: `busy` is high from the cycle after a program command until one cycle after `arr_pgm` falls, and for the whole read sequence. The block ignores loads, reads and program commands while it is busy.
- R11: When inputs arrive in the same idle cycle, a program command wins over a read request, and a read request wins over a load. The losers are dropped.
- R12: While reset is asserted, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Load one byte into the page buffer |
| ld_addr | input | 15 | Byte address of the load |
| ld_data | input | 8 | Byte to load |
| prog_start | input | 1 | Burn the buffered page |
| rd_req | input | 1 | Read one word |
| rd_addr | input | 14 | Word address of the read |
| busy | output | 1 | Operation in progress, commands dropped |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` is new |
| rd_data | output | 16 | Last word read |
| page_err | output | 1 | Pulse, load hit another page and was ignored |
| arr_row | output | 8 | Array word-line address |
| arr_col | output | 6 | Array bit-line address |
| arr_din | output | 256 | Page data toward the array |
| arr_pgm | output | 1 | Programming strobe |
| arr_rd_en | output | 1 | Array read enable |
| arr_sa_en | output | 1 | Sense-amplifier enable |
| arr_sa_grp | output | 16 | One-hot select of the sense-amplifier bank |
| arr_dout | input | 16 | Word from the sense amplifiers |

## Verification
The bench builds the block with PULSE_CYC = 40 and SETTLE_CYC = 3 in place of the real 20 ms count. This lets it run several full program cycles, and it can then verify the exact strobe width and the busy recovery edge cycle by cycle. A behavioural array in the bench ORs page data into its cells. It returns a poison word whenever the sense enable or the bank select is wrong, so a capture in the wrong cycle or from the wrong bank shows up as bad data. The reads cover sector 0 and sector 3, and the bank index ends up in its lowest and highest slot.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PGM   = 3'd1,
        ST_RCV   = 3'd2,
        ST_RADDR = 3'd3,
        ST_RSET  = 3'd4,
        ST_RSNS  = 3'd5
    } seq_st_e;

endpackage

// File: rtl/otp_page_buf.sv
module otp_page_buf #(
    parameter int PAGE_BYTES = 32,
    parameter int BADDR_W    = 15,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int TAG_W     = BADDR_W - OFF_W,
    localparam int BUF_W     = PAGE_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BADDR_W-1:0] wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               clr,
    output logic [BUF_W-1:0]   page_bits,
    output logic [TAG_W-1:0]   page_tag,
    output logic               err
);

    typedef struct packed {
        logic [BUF_W-1:0] bits;
        logic [TAG_W-1:0] tag;
        logic             open;
        logic             err;
    } pb_t;

    pb_t q, d;

    logic [OFF_W-1:0] wr_off;
    logic [TAG_W-1:0] wr_tag;

    assign wr_off = wr_addr[OFF_W-1:0];
    assign wr_tag = wr_addr[BADDR_W-1:OFF_W];

    always_comb begin
        d     = q;
        d.err = 1'b0;
        if (clr) begin
            d.bits = '0;
            d.open = 1'b0;
        end else if (wr_en) begin
            if (q.open && (q.tag != wr_tag)) begin
                d.err = 1'b1;
            end else begin
                d.bits[{wr_off, 3'b000} +: 8] = wr_data;
                d.open = 1'b1;
                d.tag  = wr_tag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign page_bits = q.bits;
    assign page_tag  = q.tag;
    assign err       = q.err;

endmodule

// File: rtl/otp_sa_decode.sv
module otp_sa_decode #(
    parameter int ADDR_W = 14,
    parameter int COL_W  = 6,
    parameter int SECT_W = 2,
    parameter int GRP_W  = 2,
    localparam int SEL_W = SECT_W + GRP_W,
    localparam int NGRP  = 1 << SEL_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    output logic [NGRP-1:0]   grp
);

    logic [SEL_W-1:0] sel;

    assign sel = {addr[ADDR_W-1 -: SECT_W], addr[COL_W-1 -: GRP_W]};

    for (genvar g = 0; g < NGRP; g++) begin : g_bank
        localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
        assign grp[g] = en && (sel == IDX);
    end

endmodule

// File: rtl/otp_seq.sv
module otp_seq import otp_pkg::*; #(
    parameter int PULSE_CYC  = 2000000,
    parameter int SETTLE_CYC = 4,
    parameter int ADDR_W     = 14,
    parameter int WORD_W     = 16,
    parameter int TAG_W      = 10,
    localparam int OFF_W     = ADDR_W - TAG_W,
    localparam int MAXC      = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC,
    localparam int CNT_W     = $clog2(MAXC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_start,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  page_tag,
    input  logic [WORD_W-1:0] arr_dout,
    output logic              ld_ok,
    output logic              buf_clr,
    output logic              busy,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_pgm,
    output logic              arr_rd_en,
    output logic              arr_sa_en
);

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic              vld;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (prog_start) begin
                    d.st   = ST_PGM;
                    d.cnt  = CNT_W'(PULSE_CYC - 1);
                    d.addr = {page_tag, {OFF_W{1'b0}}};
                end else if (rd_req) begin
                    d.st   = ST_RADDR;
                    d.addr = rd_addr;
                end
            end
            ST_PGM: begin
                if (q.cnt == '0) d.st  = ST_RCV;
                else             d.cnt = q.cnt - CNT_W'(1);
            end
            ST_RCV:   d.st = ST_IDLE;
            ST_RADDR: begin
                d.st  = ST_RSET;
                d.cnt = CNT_W'(SETTLE_CYC - 1);
            end
            ST_RSET: begin
                if (q.cnt == '0) d.st  = ST_RSNS;
                else             d.cnt = q.cnt - CNT_W'(1);
            end
            ST_RSNS: begin
                d.st   = ST_IDLE;
                d.data = arr_dout;
                d.vld  = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ld_ok     = (q.st == ST_IDLE) && ld_valid && !prog_start && !rd_req;
    assign buf_clr   = (q.st == ST_PGM) && (q.cnt == '0);
    assign busy      = (q.st != ST_IDLE);
    assign rd_valid  = q.vld;
    assign rd_data   = q.data;
    assign arr_addr  = q.addr;
    assign arr_pgm   = (q.st == ST_PGM);
    assign arr_rd_en = (q.st == ST_RSET) || (q.st == ST_RSNS);
    assign arr_sa_en = (q.st == ST_RSNS);

endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl #(
    parameter int ROW_W      = 8,
    parameter int COL_W      = 6,
    parameter int WORD_W     = 16,
    parameter int PAGE_BYTES = 32,
    parameter int SECT_W     = 2,
    parameter int GRP_W      = 2,
    parameter int PULSE_CYC  = 2000000,
    parameter int SETTLE_CYC = 4,
    localparam int ADDR_W    = ROW_W + COL_W,
    localparam int BADDR_W   = ADDR_W + $clog2(WORD_W / 8),
    localparam int BUF_W     = PAGE_BYTES * 8,
    localparam int TAG_W     = BADDR_W - $clog2(PAGE_BYTES),
    localparam int NGRP      = 1 << (SECT_W + GRP_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_valid,
    input  logic [BADDR_W-1:0] ld_addr,
    input  logic [7:0]         ld_data,
    input  logic               prog_start,
    input  logic               rd_req,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic               busy,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_data,
    output logic               page_err,
    output logic [ROW_W-1:0]   arr_row,
    output logic [COL_W-1:0]   arr_col,
    output logic [BUF_W-1:0]   arr_din,
    output logic               arr_pgm,
    output logic               arr_rd_en,
    output logic               arr_sa_en,
    output logic [NGRP-1:0]    arr_sa_grp,
    input  logic [WORD_W-1:0]  arr_dout
);

    logic              ld_ok;
    logic              buf_clr;
    logic [TAG_W-1:0]  page_tag;
    logic [ADDR_W-1:0] arr_addr;

    otp_page_buf #(
        .PAGE_BYTES(PAGE_BYTES),
        .BADDR_W   (BADDR_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ld_ok),
        .wr_addr  (ld_addr),
        .wr_data  (ld_data),
        .clr      (buf_clr),
        .page_bits(arr_din),
        .page_tag (page_tag),
        .err      (page_err)
    );

    otp_seq #(
        .PULSE_CYC (PULSE_CYC),
        .SETTLE_CYC(SETTLE_CYC),
        .ADDR_W    (ADDR_W),
        .WORD_W    (WORD_W),
        .TAG_W     (TAG_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_start(prog_start),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .ld_valid  (ld_valid),
        .page_tag  (page_tag),
        .arr_dout  (arr_dout),
        .ld_ok     (ld_ok),
        .buf_clr   (buf_clr),
        .busy      (busy),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .arr_addr  (arr_addr),
        .arr_pgm   (arr_pgm),
        .arr_rd_en (arr_rd_en),
        .arr_sa_en (arr_sa_en)
    );

    otp_sa_decode #(
        .ADDR_W(ADDR_W),
        .COL_W (COL_W),
        .SECT_W(SECT_W),
        .GRP_W (GRP_W)
    ) u_sa (
        .addr(arr_addr),
        .en  (arr_sa_en),
        .grp (arr_sa_grp)
    );

    assign arr_row = arr_addr[ADDR_W-1:COL_W];
    assign arr_col = arr_addr[COL_W-1:0];

endmodule

// File: rtl/otp_page_ctrl_chk.sv
module otp_page_ctrl_chk #(
    parameter int PULSE_CYC = 2000000,
    parameter int ROW_W     = 8,
    parameter int COL_W     = 6,
    parameter int DIN_W     = 256,
    parameter int NGRP      = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             rd_valid,
    input logic [ROW_W-1:0] arr_row,
    input logic [COL_W-1:0] arr_col,
    input logic [DIN_W-1:0] arr_din,
    input logic             arr_pgm,
    input logic             arr_rd_en,
    input logic             arr_sa_en,
    input logic [NGRP-1:0]  arr_sa_grp
);

    logic [31:0] pw_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pw_cnt <= '0;
        else if (arr_pgm) pw_cnt <= pw_cnt + 32'd1;
        else              pw_cnt <= '0;
    end

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_pgm && arr_rd_en));

    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_pgm && $past(arr_pgm)) |-> ($stable(arr_row) && $stable(arr_col) && $stable(arr_din)));

    a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_pgm) |-> (pw_cnt == 32'(PULSE_CYC)));

    a_r6_grp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        arr_sa_en |-> ($countones(arr_sa_grp) == 1));

    a_r6_grp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_sa_en |-> (arr_sa_grp == '0));

    a_r5_sense_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        arr_sa_en |-> arr_rd_en);

    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r5_valid_after_sense: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(arr_sa_en));

    a_r10_busy_in_pgm: assert property (@(posedge clk) disable iff (!rst_n)
        arr_pgm |-> busy);

    a_r10_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_pgm) |-> busy);

endmodule

bind otp_page_ctrl otp_page_ctrl_chk #(
    .PULSE_CYC(PULSE_CYC),
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .DIN_W    (BUF_W),
    .NGRP     (NGRP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .arr_row   (arr_row),
    .arr_col   (arr_col),
    .arr_din   (arr_din),
    .arr_pgm   (arr_pgm),
    .arr_rd_en (arr_rd_en),
    .arr_sa_en (arr_sa_en),
    .arr_sa_grp(arr_sa_grp)
);

// File: tb/test_otp_page_ctrl.sv
module test_otp_page_ctrl;

    localparam int P = 40;
    localparam int S = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ld_valid;
    logic [14:0]   ld_addr;
    logic [7:0]    ld_data;
    logic          prog_start;
    logic          rd_req;
    logic [13:0]   rd_addr;
    logic          busy;
    logic          rd_valid;
    logic [15:0]   rd_data;
    logic          page_err;
    logic [7:0]    arr_row;
    logic [5:0]    arr_col;
    logic [255:0]  arr_din;
    logic          arr_pgm;
    logic          arr_rd_en;
    logic          arr_sa_en;
    logic [15:0]   arr_sa_grp;
    logic [15:0]   arr_dout;

    always #5 clk = ~clk;

    otp_page_ctrl #(.PULSE_CYC(P), .SETTLE_CYC(S)) i_otp_page_ctrl (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_data(ld_data), .prog_start(prog_start), .rd_req(rd_req),
        .rd_addr(rd_addr), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .page_err(page_err), .arr_row(arr_row), .arr_col(arr_col),
        .arr_din(arr_din), .arr_pgm(arr_pgm), .arr_rd_en(arr_rd_en),
        .arr_sa_en(arr_sa_en), .arr_sa_grp(arr_sa_grp), .arr_dout(arr_dout)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural array: cells only gain ones; poison when not properly sensed
    logic [15:0] cells [int];

    always @(posedge clk) begin
        if (arr_pgm) begin
            for (int w = 0; w < 16; w++) begin
                int k;
                k = int'({arr_row, arr_col}) + w;
                if (cells.exists(k)) cells[k] = cells[k] | arr_din[16*w +: 16];
                else                 cells[k] = arr_din[16*w +: 16];
            end
        end
    end

    always @(negedge clk) begin
        int k;
        k = int'({arr_row, arr_col});
        if (arr_rd_en && arr_sa_en && arr_sa_grp == (16'd1 << {arr_row[7:6], arr_col[5:4]}))
            arr_dout <= cells.exists(k) ? cells[k] : 16'h0000;
        else
            arr_dout <= 16'hDEAD;
    end

    // Reference model: timeline of accepted commands
    int          cyc;
    int          free_at;
    int          pg_at;
    int          rd_at;
    int          err_at;
    int          pbase;
    logic [13:0] m_raddr;
    logic [15:0] m_word;
    logic [7:0]  mbuf [32];
    bit          mopen;
    int          mtag;
    logic [15:0] ref_mem [int];

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; free_at = 1; pg_at = -1000; rd_at = -1000; err_at = -1000;
            pbase = 0; mopen = 1'b0; mtag = 0; m_raddr = '0; m_word = '0;
            for (int b = 0; b < 32; b++) mbuf[b] = 8'h00;
        end else begin
            cyc++;
            if (cyc >= free_at) begin
                if (prog_start) begin
                    pg_at   = cyc;
                    free_at = cyc + P + 2;
                    pbase   = mtag * 16;
                    for (int w = 0; w < 16; w++) begin
                        logic [15:0] v;
                        v = {mbuf[2*w+1], mbuf[2*w]};
                        ref_mem[pbase + w] = (ref_mem.exists(pbase + w) ? ref_mem[pbase + w] : 16'h0) | v;
                    end
                    for (int b = 0; b < 32; b++) mbuf[b] = 8'h00;
                    mopen = 1'b0;
                end else if (rd_req) begin
                    rd_at   = cyc;
                    free_at = cyc + S + 3;
                    m_raddr = rd_addr;
                    m_word  = ref_mem.exists(int'(rd_addr)) ? ref_mem[int'(rd_addr)] : 16'h0;
                end else if (ld_valid) begin
                    if (mopen && (int'(ld_addr) / 32) != mtag) begin
                        err_at = cyc;
                    end else begin
                        mbuf[int'(ld_addr) % 32] = ld_data;
                        mopen = 1'b1;
                        mtag  = int'(ld_addr) / 32;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cyc > 0 && !done) begin
            bit          e_busy, e_pgm, e_rden, e_sa, e_vld, e_err;
            logic [15:0] e_grp;
            e_busy = (cyc >= pg_at && cyc <= pg_at + P) || (cyc >= rd_at && cyc <= rd_at + S + 1);
            e_pgm  = (cyc >= pg_at && cyc < pg_at + P);
            e_rden = (cyc >= rd_at + 1 && cyc <= rd_at + S + 1);
            e_sa   = (cyc == rd_at + S + 1);
            e_vld  = (cyc == rd_at + S + 2);
            e_err  = (cyc == err_at);
            e_grp  = e_sa ? (16'd1 << {m_raddr[13:12], m_raddr[5:4]}) : 16'h0;
            chk(busy == e_busy, "R10 busy", busy, e_busy);
            chk(arr_pgm == e_pgm, "R4 strobe", arr_pgm, e_pgm);
            chk(arr_rd_en == e_rden, "R5 R7 read enable", arr_rd_en, e_rden);
            chk(arr_sa_en == e_sa, "R5 sense enable", arr_sa_en, e_sa);
            chk(arr_sa_grp == e_grp, "R6 bank select", arr_sa_grp, e_grp);
            chk(rd_valid == e_vld, "R5 rd_valid", rd_valid, e_vld);
            chk(page_err == e_err, "R8 page_err", page_err, e_err);
            if (e_vld) chk(rd_data == m_word, "R5 R3 rd_data", rd_data, m_word);
            if (e_pgm) chk({arr_row, arr_col} == 14'(pbase), "R1 program address", {arr_row, arr_col}, pbase);
            if (e_sa)  chk({arr_row, arr_col} == m_raddr, "R1 read address", {arr_row, arr_col}, m_raddr);
        end
    end

    // Stimulus tasks, all entered and left at a falling edge
    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic load(input logic [14:0] a, input logic [7:0] v);
        ld_valid = 1'b1; ld_addr = a; ld_data = v;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic prog();
        prog_start = 1'b1;
        @(negedge clk);
        prog_start = 1'b0;
        @(negedge clk);
        wait_idle();
    endtask

    task automatic rd_check(input logic [13:0] a, input logic [15:0] e, input string tag);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_req = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (rd_valid) break;
            @(negedge clk);
        end
        chk(rd_valid && rd_data == e, tag, rd_data, e);
        wait_idle();
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 50000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 50000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ld_valid = 1'b0; ld_addr = '0; ld_data = '0;
        prog_start = 1'b0; rd_req = 1'b0; rd_addr = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!busy && !rd_valid && !page_err, "R12 status low", {busy, rd_valid, page_err}, 0);
        chk(!arr_pgm && !arr_rd_en && !arr_sa_en, "R12 array strobes low", {arr_pgm, arr_rd_en, arr_sa_en}, 0);
        chk(arr_sa_grp == 0 && rd_data == 0 && arr_din == 0, "R12 data low", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Page 5: byte order and single strobe (R2), foreign load rejected (R8)
        load(15'd160, 8'hA5);
        load(15'd161, 8'h3C);
        load(15'd170, 8'hFF);
        load(15'd191, 8'h81);
        load(15'd192, 8'h77);
        @(negedge clk);
        prog_start = 1'b1;
        @(negedge clk);
        prog_start = 1'b0;
        repeat (3) @(negedge clk);
        // R10: commands while busy are dropped
        prog_start = 1'b1; rd_req = 1'b1; rd_addr = 14'd0;
        @(negedge clk);
        prog_start = 1'b0; rd_req = 1'b0;
        load(15'd162, 8'h11);
        wait_idle();
        rd_check(14'd80, 16'h3CA5, "R2 word 0 of page");
        rd_check(14'd85, 16'h00FF, "R2 byte 10 in word 5");
        rd_check(14'd95, 16'h8100, "R2 last byte high half");
        rd_check(14'd81, 16'h0000, "R10 load during busy ignored");
        rd_check(14'd96, 16'h0000, "R8 other page not loaded");

        // R3: reprogram only adds ones; zero bits leave cells intact
        load(15'd160, 8'h5A);
        load(15'd161, 8'h00);
        prog();
        rd_check(14'd80, 16'h3CFF, "R3 OR of two programs");
        rd_check(14'd85, 16'h00FF, "R3 untouched word keeps data");

        // R9: buffer cleared after program
        load(15'd22403, 8'h42);
        prog();
        rd_check(14'd11201, 16'h4200, "R9 new page byte 3");
        rd_check(14'd11200, 16'h0000, "R9 no leftover bytes");

        // R11: program beats read beats load in one cycle
        load(15'd288, 8'h99);
        prog_start = 1'b1; rd_req = 1'b1; rd_addr = 14'd144;
        ld_valid = 1'b1; ld_addr = 15'd289; ld_data = 8'h66;
        @(negedge clk);
        prog_start = 1'b0; rd_req = 1'b0; ld_valid = 1'b0;
        @(negedge clk);
        chk(busy && arr_pgm, "R11 program won", {busy, arr_pgm}, 2'b11);
        wait_idle();
        rd_check(14'd144, 16'h0099, "R11 load dropped");

        // R6: highest sector and group, and a mid bank
        load(15'h7FFF, 8'hC3);
        prog();
        rd_check(14'h3FFF, 16'hC300, "R6 bank 15 read");
        rd_check(14'h1020, 16'h0000, "R6 bank 6 read");
        rd_check(14'h0000, 16'h0000, "R6 bank 0 read");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule